// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only first-level cache for a processor that fetches single bytes. Its main store is direct mapped, so each memory block has exactly one possible home line: the line index is taken from the address bits just above the byte offset, and only the remaining upper bits (the tag) are kept beside each line. A small fully associative victim buffer sits behind the main store. It catches lines pushed out of the main store by conflicts, which softens the thrashing seen when two blocks with the same index are used alternately.

The processor presents a byte address with `req_valid` while `cpu_ready` is high. If the main store holds the block, the byte comes back on the next cycle. If instead the victim buffer holds it, all victim entries are compared at once, and the matching victim line trades places with the line currently at that index. The byte still comes back on the next cycle, with no next-level traffic. If neither holds the block, one line is requested from the next memory level. The fetched line is installed, and the line it displaces goes into the victim buffer.

Top module: `dm_victim_cache`

## Requirements
- R1: The address splits as byte offset = bits [1:0], line index = the next IDX_W bits (bits [7:2] by default), tag = all bits above. The returned byte is byte `offset` of the 32-bit line, where byte 0 is bits [7:0].
- R2: A request whose tag matches a valid main-store line at its index gives `rsp_valid` one cycle after acceptance with `rsp_src` = 0 (main). It makes no next-level request.
- R3: A main-store miss that matches a valid victim entry gives `rsp_valid` one cycle after acceptance with `rsp_src` = 1 (victim) and no next-level request. The victim line moves into the main store, and the displaced main line takes over that victim slot.
- R4: A miss in both places raises `mem_req` with `mem_blk` = address bits [23:2]. Both are held until `mem_ack`. The cycle after the ack gives `rsp_valid` with `rsp_src` = 2 (next level), and the byte is taken from `mem_rdata`.
- R5: On a fill, a valid displaced main line is placed in the victim buffer. An invalid one is not.
- R6: Victim insertions use slots in rotating order from slot 0 after reset, so a full buffer loses the line inserted longest ago. Swaps keep a line in its slot.
- R7: Reset clears every valid bit in both structures, so the first access to any block after reset is a full miss.
- R8: `cpu_ready` is low from the cycle after a full miss is accepted until its response.
- R9: Victim entries compare the whole block number (tag and index), and at most one entry matches.
- R10: A block sharing a tag but not an index with a victim entry does not hit in the victim buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W (24) | Byte address of the request |
| cpu_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | One-cycle pulse: response byte valid |
| rsp_src | output | 2 | 0 main store, 1 victim buffer, 2 next level |
| rsp_byte | output | 8 | Requested byte |
| mem_req | output | 1 | Line fetch request to next level |
| mem_blk | output | ADDR_W-2 (22) | Block number to fetch |
| mem_ack | input | 1 | Next level delivers `mem_rdata` this cycle |
| mem_rdata | input | 32 | Fetched line |

## Verification
Directed sequences cover three cases. Two blocks sharing one index are accessed alternately, which separates a swap from a refetch. Six blocks on one index overflow the buffer, which shows that the oldest insertion is the one lost. A same-tag, different-index access shows that victim matching uses the full block number. A reset after warm-up must turn known hits back into fetches. Random traffic follows, drawn from a few tags over a few indices, with random offsets and memory latency. It mixes all three response kinds and checks each byte against a line value computed from the block number.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache with victim buffer.
package dmc_pkg;
    // Where a response byte came from; the values are visible on rsp_src.
    typedef enum logic [1:0] {
        SRC_MAIN   = 2'd0,
        SRC_VICTIM = 2'd1,
        SRC_MEM    = 2'd2
    } src_e;

    // Controller state.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } state_e;
endpackage

// File: rtl/dmc_line_store.sv
// Direct-mapped line store: one tag, one line and one valid bit per index.
// Assumes one write per cycle; a written line always becomes valid.
// Reads are combinational on rd_idx.
module dmc_line_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 16,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  vld_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] line_q [LINES];

    // Valid bits: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    // Tag and data storage, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    // Combinational read port.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_line  = line_q[rd_idx];
    end

    AST_LS_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]); // R5
endmodule

// File: rtl/dmc_victim_buf.sv
// Fully associative victim buffer. Every entry is compared with lk_blk at once.
// A swap overwrites a chosen slot in place. An insert writes the slot under a
// rotating pointer and advances it. The two are never requested together.
module dmc_victim_buf #(
    parameter int BLK_W  = 22,
    parameter int LINE_W = 32,
    parameter int VB_N   = 4,
    localparam int SLOT_W = (VB_N > 1) ? $clog2(VB_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  lk_blk,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    output logic [LINE_W-1:0] lk_line,
    input  logic              swap_en,
    input  logic [SLOT_W-1:0] swap_slot,
    input  logic              swap_vld,
    input  logic [BLK_W-1:0]  swap_blk,
    input  logic [LINE_W-1:0] swap_line,
    input  logic              ins_en,
    input  logic [BLK_W-1:0]  ins_blk,
    input  logic [LINE_W-1:0] ins_line
);
    logic [VB_N-1:0]   vld_q;
    logic [BLK_W-1:0]  blk_q  [VB_N];
    logic [LINE_W-1:0] line_q [VB_N];
    logic [SLOT_W-1:0] ptr_q;
    logic [VB_N-1:0]   match;

    // Parallel full-block comparators, one per entry.
    for (genvar g = 0; g < VB_N; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (blk_q[g] == lk_blk);
    end

    // Encode the single matching entry.
    always_comb begin
        lk_hit  = 1'b0;
        lk_slot = '0;
        lk_line = '0;
        for (int i = 0; i < VB_N; i++) begin
            if (match[i]) begin
                lk_hit  = 1'b1;
                lk_slot = SLOT_W'(i);
                lk_line = line_q[i];
            end
        end
    end

    // Entry storage: swap in place, or insert at the rotating pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < VB_N; i++) begin
                if (swap_en && swap_slot == SLOT_W'(i)) begin
                    vld_q[i]  <= swap_vld;
                    blk_q[i]  <= swap_blk;
                    line_q[i] <= swap_line;
                end else if (ins_en && ptr_q == SLOT_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    blk_q[i]  <= ins_blk;
                    line_q[i] <= ins_line;
                end
            end
        end
    end

    // Rotating insertion pointer, so the oldest insertion is replaced first.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else if (ins_en) ptr_q <= (ptr_q == SLOT_W'(VB_N - 1)) ? '0 : ptr_q + 1'b1;
    end

    AST_VB_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R9
    AST_VB_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(swap_en && ins_en)); // R6
    AST_VB_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_en |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/dm_victim_cache.sv
// Read-only direct-mapped cache with a victim buffer behind it.
// A request is accepted when cpu_ready is high. Main and victim lookups are
// combinational in the accept cycle, and hits answer one cycle later. A full
// miss holds mem_req until mem_ack and answers the cycle after the ack.
// Assumes mem_ack is asserted only while mem_req is high.
module dm_victim_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6,
    parameter int LINE_W = 32,
    parameter int VB_N   = 4,
    localparam int OFFS_W = $clog2(LINE_W / 8),
    localparam int BLK_W  = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              cpu_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_src,
    output logic [7:0]        rsp_byte,
    output logic              mem_req,
    output logic [BLK_W-1:0]  mem_blk,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    localparam int TAG_W  = BLK_W - IDX_W;
    localparam int SLOT_W = (VB_N > 1) ? $clog2(VB_N) : 1;

    state_e            state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [OFFS_W-1:0] cur_off;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [BLK_W-1:0]  cur_blk;

    logic              m_valid;
    logic [TAG_W-1:0]  m_tag;
    logic [LINE_W-1:0] m_line;
    logic              main_hit;
    logic              vb_hit;
    logic [SLOT_W-1:0] vb_slot;
    logic [LINE_W-1:0] vb_line;
    logic              accept, do_swap, fill;
    src_e              src_q;

    // Field split of the active address: the new request when idle, else the held one.
    always_comb begin
        cur_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
        cur_off  = cur_addr[OFFS_W-1:0];
        cur_idx  = cur_addr[OFFS_W +: IDX_W];
        cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
        cur_blk  = cur_addr[ADDR_W-1:OFFS_W];
    end

    // Decision signals for this cycle.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid;
        main_hit = m_valid && (m_tag == cur_tag);
        do_swap  = accept && !main_hit && vb_hit;
        fill     = (state_q == ST_FETCH) && mem_ack;
    end

    dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_valid (m_valid),
        .rd_tag   (m_tag),
        .rd_line  (m_line),
        .wr_en    (do_swap || fill),
        .wr_idx   (cur_idx),
        .wr_tag   (cur_tag),
        .wr_line  (fill ? mem_rdata : vb_line)
    );

    dmc_victim_buf #(.BLK_W(BLK_W), .LINE_W(LINE_W), .VB_N(VB_N)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_blk    (cur_blk),
        .lk_hit    (vb_hit),
        .lk_slot   (vb_slot),
        .lk_line   (vb_line),
        .swap_en   (do_swap),
        .swap_slot (vb_slot),
        .swap_vld  (m_valid),
        .swap_blk  ({m_tag, cur_idx}),
        .swap_line (m_line),
        .ins_en    (fill && m_valid),
        .ins_blk   ({m_tag, cur_idx}),
        .ins_line  (m_line)
    );

    // Control: answer hits at once, run a fetch for a full miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            mem_req   <= 1'b0;
            mem_blk   <= '0;
            rsp_valid <= 1'b0;
            src_q     <= SRC_MAIN;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (main_hit) begin
                            rsp_valid <= 1'b1;
                            src_q     <= SRC_MAIN;
                            rsp_byte  <= m_line[{cur_off, 3'b000} +: 8];
                        end else if (vb_hit) begin
                            rsp_valid <= 1'b1;
                            src_q     <= SRC_VICTIM;
                            rsp_byte  <= vb_line[{cur_off, 3'b000} +: 8];
                        end else begin
                            state_q <= ST_FETCH;
                            addr_q  <= req_addr;
                            mem_req <= 1'b1;
                            mem_blk <= cur_blk;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        state_q   <= ST_IDLE;
                        mem_req   <= 1'b0;
                        rsp_valid <= 1'b1;
                        src_q     <= SRC_MEM;
                        rsp_byte  <= mem_rdata[{cur_off, 3'b000} +: 8];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ready = (state_q == ST_IDLE);
    assign rsp_src   = src_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_blk)); // R4
    AST_RSP_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> rsp_valid && (rsp_src == SRC_MEM) && cpu_ready); // R4
    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_src != SRC_MEM) |-> !mem_req); // R2
    AST_BUSY_FETCHING: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> mem_req); // R8
endmodule

// File: tb/sim_dm_victim_cache.sv
`timescale 1ns/1ps
module sim_dm_victim_cache;
    localparam int VBN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        cpu_ready, rsp_valid, mem_req;
    logic [1:0]  rsp_src;
    logic [7:0]  rsp_byte;
    logic [21:0] mem_blk;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int fetches = 0;

    // Reference state kept from the requirements.
    logic [15:0] mt [64];
    logic        mv [64];
    logic [31:0] md [64];
    logic [21:0] vb [VBN];
    logic        vv [VBN];
    logic [31:0] vd [VBN];
    int          vptr;

    always #2.5 clk = ~clk;

    dm_victim_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_src(rsp_src),
        .rsp_byte(rsp_byte), .mem_req(mem_req), .mem_blk(mem_blk),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [21:0] b);
        return ({10'd0, b} * 32'h9E37_79B1) + 32'h1234_5677;
    endfunction

    function automatic logic [23:0] mk(input logic [15:0] t, input logic [5:0] i, input logic [1:0] o);
        return {t, i, o};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Next-level memory: random latency 0..3, ack with the computed line.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                repeat ($urandom % 4) @(negedge clk);
                mem_ack   = 1'b1;
                mem_rdata = mem_word(mem_blk);
                fetches++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) mv[i] = 1'b0;
        for (int i = 0; i < VBN; i++) vv[i] = 1'b0;
        vptr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One read; the model predicts the source and byte.
    task automatic access(input logic [23:0] a, output logic [1:0] got);
        logic [5:0]  idx = a[7:2];
        logic [15:0] tag = a[23:8];
        logic [21:0] blk = a[23:2];
        logic [1:0]  off = a[1:0];
        logic [1:0]  esrc;
        logic [31:0] eline;
        logic [21:0] tb_blk;
        logic        tb_v;
        logic [31:0] tb_d;
        int          slot = -1;
        int          f0, n;
        string       rq;
        if (mv[idx] && mt[idx] == tag) begin
            esrc = 2'd0; eline = md[idx];
        end else begin
            for (int i = 0; i < VBN; i++) if (vv[i] && vb[i] == blk) slot = i;
            if (slot >= 0) begin
                esrc = 2'd1; eline = vd[slot];
                tb_blk = {mt[idx], idx}; tb_v = mv[idx]; tb_d = md[idx];
                mt[idx] = tag; md[idx] = eline; mv[idx] = 1'b1;
                vb[slot] = tb_blk; vv[slot] = tb_v; vd[slot] = tb_d;
            end else begin
                esrc = 2'd2; eline = mem_word(blk);
                if (mv[idx]) begin
                    vb[vptr] = {mt[idx], idx}; vv[vptr] = 1'b1; vd[vptr] = md[idx];
                    vptr = (vptr + 1) % VBN;
                end
                mt[idx] = tag; md[idx] = eline; mv[idx] = 1'b1;
            end
        end
        rq = (esrc == 2'd0) ? "R2" : (esrc == 2'd1) ? "R3" : "R4";
        @(negedge clk);
        check(cpu_ready == 1'b1, "R8", cpu_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        f0 = fetches;
        @(negedge clk);
        req_valid = 1'b0;
        if (esrc == 2'd2) begin
            check(mem_req && mem_blk == blk, "R4", mem_blk, blk);
            check(cpu_ready == 1'b0, "R8", cpu_ready, 0);
        end
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        got = rsp_src;
        check(rsp_valid == 1'b1, rq, rsp_valid, 1);
        check(rsp_src == esrc, rq, rsp_src, esrc);
        check(rsp_byte == eline[8*off +: 8], "R1", rsp_byte, eline[8*off +: 8]);
        check((fetches - f0) == ((esrc == 2'd2) ? 1 : 0), rq, fetches - f0, (esrc == 2'd2) ? 1 : 0);
    endtask

    initial begin
        logic [1:0] s;
        void'($urandom(32'd2024));
        do_reset();
        @(negedge clk);
        check(cpu_ready && !rsp_valid && !mem_req, "R7", {cpu_ready, rsp_valid, mem_req}, 3'b100);

        // Two blocks on index 0 alternate: swap instead of refetch (R3, R5).
        access(mk(16'h0001, 6'd0, 2'd1), s); check(s == 2'd2, "R7", s, 2);
        access(mk(16'h0002, 6'd0, 2'd3), s); check(s == 2'd2, "R4", s, 2);
        access(mk(16'h0001, 6'd0, 2'd2), s); check(s == 2'd1, "R5", s, 1);
        access(mk(16'h0002, 6'd0, 2'd0), s); check(s == 2'd1, "R3", s, 1);
        access(mk(16'h0002, 6'd0, 2'd1), s); check(s == 2'd0, "R2", s, 0);
        // Same tag, other index: no victim hit (R10, R9).
        access(mk(16'h0001, 6'd1, 2'd0), s); check(s == 2'd2, "R10", s, 2);
        access(mk(16'h0001, 6'd0, 2'd0), s); check(s == 2'd1, "R9", s, 1);

        // Reset forgets everything (R7).
        do_reset();
        access(mk(16'h0001, 6'd0, 2'd0), s); check(s == 2'd2, "R7", s, 2);

        // Overflow on index 5: oldest insertion lost (R6).
        do_reset();
        for (int t = 10; t < 16; t++) access(mk(16'(t), 6'd5, 2'(t)), s);
        access(mk(16'd10, 6'd5, 2'd0), s); check(s == 2'd2, "R6", s, 2);
        access(mk(16'd12, 6'd5, 2'd3), s); check(s == 2'd1, "R6", s, 1);

        // Random traffic over a few tags and indices.
        for (int k = 0; k < 400; k++) begin
            access(mk(16'hA500 | 16'($urandom % 6), 6'($urandom % 3), 2'($urandom % 4)), s);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule